// File: doc/BRIEF.md
# ASID-Tagged Multi-Way Address Translation Buffer

This block turns a 32-bit virtual address into a physical address. It looks the address up in one of two set-associative translation buffers, one for instruction fetches and one for data. Each side has several ways. Each way covers a fixed page size, and the way's set index comes from the address bits just above its page offset. An entry holds a virtual page, a physical page, an 8-bit address-space tag and a 4-bit attribute. A tag of zero marks the entry as empty.

A tag is turned into a privilege ring by searching the four bytes of a ring-tag register. The ring is then compared with the privilege index of the requester. The attribute gives access rights and a cache mode. The rights are then trimmed to the side that was looked up. Every lookup returns a cause code. Zero means success. Non-zero codes report a miss, multiple hits, a privilege violation or a denied access, with separate codes for the instruction side and the data side.

The lookup is combinational, and its result is registered, so the answer appears one clock after the request. Entries and the ring-tag register are written through simple write ports. Refill from page tables is handled by a neighbouring block.

Top module: `asid_tlb`

## Requirements
- R1: Synchronous active-high reset clears all result outputs to zero, loads the ring-tag register with 0x04030201 and sets the tag of every entry on both sides to 0, so that every lookup after reset misses.
- R2: Way w covers pages of 2^(12+2w) bytes and is indexed by the two address bits directly above that page offset. An entry hits only when its tag is non-zero and its virtual page equals the address bits above the page offset.
- R3: When no way hits, the cause is 16 for a fetch and 24 for a data access.
- R4: When more than one way hits, the cause is 17 for a fetch and 25 for a data access.
- R5: The ring of a single hit is the lowest byte index i (0..3) for which ring-tag bits [8i+7:8i] equal the entry's tag, or 3 if no byte matches. If the ring is below the privilege input, the cause is 18 for a fetch and 26 for a data access. This check takes priority over the rights check.
- R6: Rights are bit 0 read, bit 1 write and bit 2 execute. The data side clears execute, and the instruction side keeps only execute. Access encoding is 0 load, 1 store, 2 fetch, and 3 acts as a load. A load needs read, a store needs write and a fetch needs execute. Otherwise the cause is 28 (load), 29 (store) or 20 (fetch).
- R7: An attribute below 12 grants read, write from attribute bit 1 and execute from bit 0. Its bits [3:2] give the cache mode: 00 bypass (1), 01 write-back (2), 10 write-through (3). Attribute 13 grants read and write with isolate mode (4). Attributes 12, 14 and 15 grant nothing, with mode 0.
- R8: On success, the physical address is the entry's physical page ORed with the address bits below the way's page boundary, and the page size equals the way's page size.
- R9: A result appears on the outputs one clock after the request. On any non-zero cause, the address, size, rights and mode outputs are zero.
- R10: An entry write (side 0 instruction, side 1 data) changes only the addressed way and index on the chosen side. A fetch uses only the instruction side, and loads and stores use only the data side. A ring-tag write takes effect on the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_priv | input | 2 | Current privilege index |
| rtag_we | input | 1 | Ring-tag register write enable |
| rtag_wdata | input | 32 | Ring-tag register write value |
| wr_en | input | 1 | Entry write enable |
| wr_data_side | input | 1 | Entry write side: 0 instruction, 1 data |
| wr_way | input | 2 | Entry write way |
| wr_idx | input | 2 | Entry write set index |
| wr_vpage | input | 32 | Entry virtual page |
| wr_ppage | input | 32 | Entry physical page |
| wr_tag | input | 8 | Entry address-space tag (0 = empty) |
| wr_attr | input | 4 | Entry attribute |
| pa | output | 32 | Translated physical address |
| page_size | output | 32 | Page size in bytes |
| rights | output | 3 | Granted rights {execute, write, read} |
| cache_mode | output | 3 | 0 none, 1 bypass, 2 write-back, 3 write-through, 4 isolate |
| cause | output | 6 | Result cause, 0 = success |

## Verification
Lookups are run against single hits in the smallest and the largest way, on both sides. These separate the per-way index and mask choice, and show whether the instruction and data tables stay independent. The same address is then hit in two ways, and hit again after one of the two entries has its tag cleared. This tells a real multi-hit apart from the treatment of an empty entry. The ring-tag register is reloaded with rotated, duplicated and non-matching byte patterns, which checks the byte search order and the no-match fallback against the privilege input. The attribute sweep covers every cache mode, the isolate code and a no-access code. Loads, stores and fetches are each run on these entries, so that side trimming and per-access denial causes can be told apart.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        CM_NONE    = 3'd0,
        CM_BYPASS  = 3'd1,
        CM_WBACK   = 3'd2,
        CM_WTHRU   = 3'd3,
        CM_ISOLATE = 3'd4
    } cmode_e;

    typedef enum logic [5:0] {
        C_OK         = 6'd0,
        C_IMISS      = 6'd16,
        C_IMULTI     = 6'd17,
        C_IPRIV      = 6'd18,
        C_FETCH_DENY = 6'd20,
        C_DMISS      = 6'd24,
        C_DMULTI     = 6'd25,
        C_DPRIV      = 6'd26,
        C_LOAD_DENY  = 6'd28,
        C_STORE_DENY = 6'd29
    } cause_e;

    localparam int RIGHT_R = 0;
    localparam int RIGHT_W = 1;
    localparam int RIGHT_X = 2;

    localparam logic [31:0] RTAG_RESET = 32'h0403_0201;

    typedef struct packed {
        logic [31:0] vpage;
        logic [31:0] ppage;
        logic [7:0]  tag;
        logic [3:0]  attr;
    } tlb_ent_t;

    typedef struct packed {
        logic [31:0] ppage;
        logic [7:0]  tag;
        logic [3:0]  attr;
    } tlb_out_t;

    typedef struct packed {
        logic [2:0] rights;
        cmode_e     cmode;
    } attr_dec_t;

    typedef struct packed {
        cause_e      cause;
        logic [31:0] pa;
        logic [31:0] size;
        logic [2:0]  rights;
        cmode_e      cmode;
    } tlb_res_t;

    function automatic logic [31:0] way_mask(input int shift);
        return ~((32'd1 << shift) - 32'd1);
    endfunction

    function automatic attr_dec_t decode_attr(input logic [3:0] a);
        attr_dec_t d;
        d.rights = '0;
        d.cmode  = CM_NONE;
        if (a < 4'd12) begin
            d.rights[RIGHT_R] = 1'b1;
            d.rights[RIGHT_W] = a[1];
            d.rights[RIGHT_X] = a[0];
            case (a[3:2])
                2'b00:   d.cmode = CM_BYPASS;
                2'b01:   d.cmode = CM_WBACK;
                default: d.cmode = CM_WTHRU;
            endcase
        end else if (a == 4'd13) begin
            d.rights = 3'b011;
            d.cmode  = CM_ISOLATE;
        end
        return d;
    endfunction

    // lowest matching byte wins; no match falls back to the least privileged ring
    function automatic logic [1:0] ring_of(input logic [31:0] rtag, input logic [7:0] tag);
        logic [1:0] r;
        r = 2'd3;
        for (int i = 3; i >= 0; i--) begin
            if (rtag[8*i +: 8] == tag) r = 2'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/tlb_side.sv
module tlb_side
    import asid_tlb_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int SETS       = 4,
    parameter int BASE_SHIFT = 12,
    parameter int SHIFT_STEP = 2,
    localparam int WAY_W     = $clog2(WAYS),
    localparam int IDX_W     = $clog2(SETS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [WAY_W-1:0]      wway,
    input  logic [IDX_W-1:0]      widx,
    input  tlb_ent_t              wdata,
    input  logic [31:0]           va,
    output logic [WAYS-1:0]       hit,
    output tlb_out_t [WAYS-1:0]   ent
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam int          SH  = BASE_SHIFT + w * SHIFT_STEP;
        localparam logic [31:0] MSK = way_mask(SH);

        tlb_ent_t          mem [SETS];
        logic [IDX_W-1:0]  idx;
        tlb_ent_t          cur;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) mem[s].tag <= '0;
            end else if (we && (wway == WAY_W'(w))) begin
                mem[widx] <= wdata;
            end
        end

        always_comb begin
            idx        = va[SH +: IDX_W];
            cur        = mem[idx];
            hit[w]     = (cur.tag != 8'd0) && (((cur.vpage ^ va) & MSK) == 32'd0);
            ent[w]     = '{ppage: cur.ppage, tag: cur.tag, attr: cur.attr};
        end
    end

endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
    import asid_tlb_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int BASE_SHIFT = 12,
    parameter int SHIFT_STEP = 2
) (
    input  logic [31:0]          va,
    input  logic [1:0]           acc,
    input  logic [1:0]           priv,
    input  logic [31:0]          rtag,
    input  logic [WAYS-1:0]      hit,
    input  tlb_out_t [WAYS-1:0]  ent,
    output tlb_res_t             res
);

    logic [31:0] sel_ppage;
    logic [7:0]  sel_tag;
    logic [3:0]  sel_attr;
    logic [31:0] msk;
    int          nhits;
    logic        is_fetch;
    logic        is_store;
    logic [1:0]  ring;
    attr_dec_t   dec;
    logic [2:0]  eff;
    logic        granted;

    always_comb begin
        sel_ppage = '0;
        sel_tag   = '0;
        sel_attr  = '0;
        msk       = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit[w]) begin
                sel_ppage = ent[w].ppage;
                sel_tag   = ent[w].tag;
                sel_attr  = ent[w].attr;
                msk       = way_mask(BASE_SHIFT + w * SHIFT_STEP);
            end
        end
        nhits    = $countones(hit);
        is_fetch = (acc == ACC_FETCH);
        is_store = (acc == ACC_STORE);
        ring     = ring_of(rtag, sel_tag);
        dec      = decode_attr(sel_attr);
        eff      = is_fetch ? (dec.rights & 3'b100) : (dec.rights & 3'b011);
        granted  = is_fetch ? eff[RIGHT_X] : (is_store ? eff[RIGHT_W] : eff[RIGHT_R]);

        res = '0;
        if (nhits == 0) begin
            res.cause = is_fetch ? C_IMISS : C_DMISS;
        end else if (nhits > 1) begin
            res.cause = is_fetch ? C_IMULTI : C_DMULTI;
        end else if (ring < priv) begin
            res.cause = is_fetch ? C_IPRIV : C_DPRIV;
        end else if (!granted) begin
            res.cause = is_fetch ? C_FETCH_DENY : (is_store ? C_STORE_DENY : C_LOAD_DENY);
        end else begin
            res.cause  = C_OK;
            res.pa     = (sel_ppage & msk) | (va & ~msk);
            res.size   = ~msk + 32'd1;
            res.rights = eff;
            res.cmode  = dec.cmode;
        end
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int SETS       = 4,
    parameter int BASE_SHIFT = 12,
    parameter int SHIFT_STEP = 2,
    localparam int WAY_W     = $clog2(WAYS),
    localparam int IDX_W     = $clog2(SETS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [31:0]        lk_vaddr,
    input  logic [1:0]         lk_acc,
    input  logic [1:0]         lk_priv,
    input  logic               rtag_we,
    input  logic [31:0]        rtag_wdata,
    input  logic               wr_en,
    input  logic               wr_data_side,
    input  logic [WAY_W-1:0]   wr_way,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [31:0]        wr_vpage,
    input  logic [31:0]        wr_ppage,
    input  logic [7:0]         wr_tag,
    input  logic [3:0]         wr_attr,
    output logic [31:0]        pa,
    output logic [31:0]        page_size,
    output logic [2:0]         rights,
    output logic [2:0]         cache_mode,
    output logic [5:0]         cause
);

    localparam int NSIDES = 2; // 0 instruction, 1 data

    logic [31:0]          rtag_q;
    tlb_ent_t             wentry;
    logic [WAYS-1:0]      side_hit [NSIDES];
    tlb_out_t [WAYS-1:0]  side_ent [NSIDES];
    logic                 use_data;
    tlb_res_t             res_d;
    tlb_res_t             res_q;

    always_ff @(posedge clk) begin
        if (rst)          rtag_q <= RTAG_RESET;
        else if (rtag_we) rtag_q <= rtag_wdata;
    end

    assign wentry = '{vpage: wr_vpage, ppage: wr_ppage, tag: wr_tag, attr: wr_attr};

    for (genvar s = 0; s < NSIDES; s++) begin : g_side
        tlb_side #(
            .WAYS(WAYS), .SETS(SETS),
            .BASE_SHIFT(BASE_SHIFT), .SHIFT_STEP(SHIFT_STEP)
        ) u_side (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_en && (wr_data_side == 1'(s))),
            .wway  (wr_way),
            .widx  (wr_idx),
            .wdata (wentry),
            .va    (lk_vaddr),
            .hit   (side_hit[s]),
            .ent   (side_ent[s])
        );
    end

    assign use_data = (lk_acc != ACC_FETCH);

    tlb_resolve #(
        .WAYS(WAYS), .BASE_SHIFT(BASE_SHIFT), .SHIFT_STEP(SHIFT_STEP)
    ) u_resolve (
        .va   (lk_vaddr),
        .acc  (lk_acc),
        .priv (lk_priv),
        .rtag (rtag_q),
        .hit  (use_data ? side_hit[1] : side_hit[0]),
        .ent  (use_data ? side_ent[1] : side_ent[0]),
        .res  (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign pa         = res_q.pa;
    assign page_size  = res_q.size;
    assign rights     = res_q.rights;
    assign cache_mode = res_q.cmode;
    assign cause      = res_q.cause;

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  lk_acc,
    input logic [31:0] pa,
    input logic [31:0] page_size,
    input logic [2:0]  rights,
    input logic [2:0]  cache_mode,
    input logic [5:0]  cause
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cause == 6'd0 && pa == 32'd0 && rights == 3'd0));

    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (cause != 6'd0) |-> (pa == 32'd0 && page_size == 32'd0 && rights == 3'd0 && cache_mode == 3'd0));

    p_size_pow2_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cause == 6'd0) |-> ($countones(page_size) == 1));

    p_fetch_only_x_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lk_acc) == 2'd2 && cause == 6'd0) |-> (rights == 3'b100));

    p_data_no_x_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lk_acc) != 2'd2) |-> (rights[2] == 1'b0));

    p_store_has_w_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lk_acc) == 2'd1 && cause == 6'd0) |-> rights[1]);

    p_data_cause_side_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lk_acc) != 2'd2) |->
        (cause != 6'd16 && cause != 6'd17 && cause != 6'd18 && cause != 6'd20));

endmodule

bind asid_tlb asid_tlb_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_acc     (lk_acc),
    .pa         (pa),
    .page_size  (page_size),
    .rights     (rights),
    .cache_mode (cache_mode),
    .cause      (cause)
);

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
module sim_asid_tlb;

    localparam logic [5:0] K_OK = 6'd0, K_IMISS = 6'd16, K_IMULTI = 6'd17, K_IPRIV = 6'd18,
                           K_FDENY = 6'd20, K_DMISS = 6'd24, K_DMULTI = 6'd25, K_DPRIV = 6'd26,
                           K_LDENY = 6'd28, K_SDENY = 6'd29;
    localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic [1:0]  lk_priv = '0;
    logic        rtag_we = 1'b0;
    logic [31:0] rtag_wdata = '0;
    logic        wr_en = 1'b0;
    logic        wr_data_side = 1'b0;
    logic [1:0]  wr_way = '0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_vpage = '0;
    logic [31:0] wr_ppage = '0;
    logic [7:0]  wr_tag = '0;
    logic [3:0]  wr_attr = '0;
    logic [31:0] pa;
    logic [31:0] page_size;
    logic [2:0]  rights;
    logic [2:0]  cache_mode;
    logic [5:0]  cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    asid_tlb u0 (.*);

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wr_ent(input logic side, input logic [1:0] way, input logic [1:0] idx,
                          input logic [31:0] vp, input logic [31:0] pp,
                          input logic [7:0] tg, input logic [3:0] at);
        wr_en = 1'b1; wr_data_side = side; wr_way = way; wr_idx = idx;
        wr_vpage = vp; wr_ppage = pp; wr_tag = tg; wr_attr = at;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic wr_rtag(input logic [31:0] v);
        rtag_we = 1'b1; rtag_wdata = v;
        @(posedge clk);
        #1 rtag_we = 1'b0;
    endtask

    task automatic look(input string tag, input logic [31:0] va, input logic [1:0] acc,
                        input logic [1:0] pv, input logic [5:0] ec, input logic [31:0] epa,
                        input logic [31:0] esz, input logic [2:0] er, input logic [2:0] em);
        lk_vaddr = va; lk_acc = acc; lk_priv = pv;
        @(posedge clk);
        #1;
        n_checks++;
        if (cause !== ec || pa !== epa || page_size !== esz || rights !== er || cache_mode !== em) begin
            n_fail++;
            $display("FAIL %s: got cause=%0d pa=%h size=%h rights=%b mode=%0d, expected cause=%0d pa=%h size=%h rights=%b mode=%0d",
                     tag, cause, pa, page_size, rights, cache_mode, ec, epa, esz, er, em);
        end
    endtask

    task automatic fault(input string tag, input logic [31:0] va, input logic [1:0] acc,
                         input logic [1:0] pv, input logic [5:0] ec);
        look(tag, va, acc, pv, ec, 32'd0, 32'd0, 3'd0, 3'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk);
        #1;
        n_checks++;
        if (cause !== 6'd0 || pa !== 32'd0 || rights !== 3'd0 || page_size !== 32'd0) begin
            n_fail++;
            $display("FAIL R1 reset outputs: cause=%0d pa=%h rights=%b size=%h expected all zero",
                     cause, pa, rights, page_size);
        end
        rst = 1'b0;
        wr_ent(1'b1, 2'd0, 2'd1, 32'h1234_5000, 32'hABCD_E000, 8'd1, 4'd7);
        do_reset();
        fault("R1 entry tags cleared by reset", 32'h1234_5678, LD, 2'd0, K_DMISS);
    endtask

    task automatic t_basic();
        wr_ent(1'b1, 2'd0, 2'd1, 32'h1234_5000, 32'hABCD_E000, 8'd1, 4'd7);
        look("R2 R8 R9 data hit way0 load", 32'h1234_5678, LD, 2'd0, K_OK,
             32'hABCD_E678, 32'h0000_1000, 3'b011, 3'd2);
        look("R7 data hit way0 store", 32'h1234_5678, ST, 2'd0, K_OK,
             32'hABCD_E678, 32'h0000_1000, 3'b011, 3'd2);
        fault("R2 R3 wrong page same index misses", 32'h1235_5678, LD, 2'd0, K_DMISS);
    endtask

    task automatic t_readonly();
        wr_ent(1'b1, 2'd0, 2'd3, 32'h2000_3000, 32'h0005_0000, 8'd1, 4'd4);
        look("R7 read-only load", 32'h2000_3000, LD, 2'd0, K_OK,
             32'h0005_0000, 32'h0000_1000, 3'b001, 3'd2);
        fault("R6 store to read-only", 32'h2000_3000, ST, 2'd0, K_SDENY);
    endtask

    task automatic t_fetch();
        wr_ent(1'b0, 2'd1, 2'd2, 32'h4000_8000, 32'h00F0_4000, 8'd2, 4'd9);
        look("R6 R8 fetch hit way1", 32'h4000_8123, FE, 2'd1, K_OK,
             32'h00F0_4123, 32'h0000_4000, 3'b100, 3'd3);
        fault("R5 fetch privilege", 32'h4000_8123, FE, 2'd2, K_IPRIV);
        fault("R10 data side separate from instruction side", 32'h4000_8123, LD, 2'd0, K_DMISS);
        wr_ent(1'b0, 2'd0, 2'd0, 32'h5000_0000, 32'h0000_0000, 8'd1, 4'd2);
        fault("R6 fetch without execute", 32'h5000_0010, FE, 2'd0, K_FDENY);
        fault("R3 instruction miss", 32'h7000_0000, FE, 2'd0, K_IMISS);
    endtask

    task automatic t_multi();
        wr_ent(1'b1, 2'd2, 2'd0, 32'h1234_0000, 32'h0000_0000, 8'd1, 4'd7);
        fault("R4 data multi-hit", 32'h1234_5678, LD, 2'd0, K_DMULTI);
        wr_ent(1'b1, 2'd2, 2'd0, 32'h1234_0000, 32'h0000_0000, 8'd0, 4'd7);
        look("R2 tag zero entry ignored", 32'h1234_5678, LD, 2'd0, K_OK,
             32'hABCD_E678, 32'h0000_1000, 3'b011, 3'd2);
        wr_ent(1'b0, 2'd0, 2'd0, 32'h4000_8000, 32'h0000_0000, 8'd2, 4'd9);
        fault("R4 instruction multi-hit", 32'h4000_8123, FE, 2'd0, K_IMULTI);
    endtask

    task automatic t_ring();
        fault("R5 default ring-tag gives ring0 below priv1", 32'h1234_5678, LD, 2'd1, K_DPRIV);
        wr_rtag(32'h0102_0304);
        look("R5 R10 tag at byte3 gives ring3", 32'h1234_5678, LD, 2'd3, K_OK,
             32'hABCD_E678, 32'h0000_1000, 3'b011, 3'd2);
        wr_rtag(32'h0101_0101);
        fault("R5 duplicate bytes lowest wins", 32'h1234_5678, LD, 2'd1, K_DPRIV);
        look("R5 duplicate bytes priv0 allowed", 32'h1234_5678, LD, 2'd0, K_OK,
             32'hABCD_E678, 32'h0000_1000, 3'b011, 3'd2);
        wr_rtag(32'h0403_0202);
        look("R5 no matching byte gives ring3", 32'h1234_5678, ST, 2'd3, K_OK,
             32'hABCD_E678, 32'h0000_1000, 3'b011, 3'd2);
        wr_rtag(32'h0403_0201);
    endtask

    task automatic t_attrs();
        wr_ent(1'b1, 2'd1, 2'd1, 32'h6000_4000, 32'h0010_0000, 8'd1, 4'd13);
        look("R7 attr13 isolate load", 32'h6000_4000, LD, 2'd0, K_OK,
             32'h0010_0000, 32'h0000_4000, 3'b011, 3'd4);
        look("R7 attr13 isolate store", 32'h6000_4000, ST, 2'd0, K_OK,
             32'h0010_0000, 32'h0000_4000, 3'b011, 3'd4);
        wr_ent(1'b1, 2'd1, 2'd1, 32'h6000_4000, 32'h0010_0000, 8'd1, 4'd12);
        fault("R7 attr12 no access", 32'h6000_4000, LD, 2'd0, K_LDENY);
        wr_ent(1'b1, 2'd1, 2'd1, 32'h6000_4000, 32'h0010_0000, 8'd1, 4'd3);
        look("R7 attr3 bypass", 32'h6000_4000, LD, 2'd0, K_OK,
             32'h0010_0000, 32'h0000_4000, 3'b011, 3'd1);
        wr_ent(1'b1, 2'd1, 2'd1, 32'h6000_4000, 32'h0010_0000, 8'd1, 4'd11);
        look("R7 attr11 write-through", 32'h6000_4000, ST, 2'd0, K_OK,
             32'h0010_0000, 32'h0000_4000, 3'b011, 3'd3);
    endtask

    task automatic t_big_page();
        wr_ent(1'b1, 2'd3, 2'd1, 32'h8004_0000, 32'h01C0_0000, 8'd1, 4'd5);
        look("R8 largest way address and size", 32'h8007_FFFC, LD, 2'd0, K_OK,
             32'h01C3_FFFC, 32'h0004_0000, 3'b001, 3'd2);
        fault("R6 store to read-only large page", 32'h8007_FFFC, ST, 2'd0, K_SDENY);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_basic();
        t_readonly();
        t_fetch();
        t_multi();
        t_ring();
        t_attrs();
        t_big_page();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
            $finish;
        end
    end

endmodule